// File: doc/BRIEF.md
# Host Bridge Configuration Register File

This block holds the 256-byte configuration space of a host-bridge device and serves it through a simple synchronous byte port. Each request carries a function number, an 8-bit register offset, write data, a read strobe and a write strobe. Only function 0 is implemented. Every write passes through a per-offset rule before it is stored. Under these rules, identification and class bytes cannot be changed, a large block of the header is write-ignored, and the command and status bytes keep only selected bits while other bits are held at fixed values.

Seven consecutive bytes, starting at offset 0x59, hold the memory shadow attributes for the legacy region. These bytes are exported as a flat vector for a separate region decoder. A dedicated bus-reset input clears the lowest of these bytes and leaves the rest of the space untouched. The full chip reset loads the device's default contents. Read data is registered.

Top module: `host_cfg_space`

## Requirements
- R1: After `rst`, every byte is zero except these: 0x00=0x86, 0x01=0x80, 0x02=0x37, 0x03=0x12, 0x04=0x03, 0x05=0x01, 0x06=0x80, 0x08=0x02, 0x0B=0x06, 0x2C=0xF4, 0x2D=0x1A, 0x2F=0x11, 0x51=0x01, 0x53=0x80, 0x57=0x01, 0x58=0x10, 0x5A..0x5E=0x11, 0x5F=0x31, 0x72=0x02. `rd_data` is 0x00 while `rst` is held.
- R2: A write whose `req_func` is not 0 changes nothing. A read whose `req_func` is not 0 returns 0xFF.
- R3: Writes to offsets 0x00–0x03, 0x08–0x0C, 0x0E and 0x10–0x4E are ignored.
- R4: A write to 0x04 stores (data AND 0x02) OR 0x04. Writes to 0x05 and 0x06 store 0x00.
- R5: A write to 0x07 stores (data AND 0x80) OR 0x02.
- R6: A function-0 write to any other offset (for example 0x0D, 0x0F, 0x4F, 0x50, 0x59–0x5F, 0x72, 0xFF) stores the data unchanged.
- R7: A read strobe sampled at one clock edge puts the addressed byte on `rd_data` at that edge. A write in the same cycle is not yet visible. `rd_data` holds its value in cycles without a read strobe.
- R8: `bus_rst` clears offset 0x59 at its clock edge, leaves all other bytes unchanged, and takes precedence over a write to 0x59 in the same cycle.
- R9: `shadow_attr` carries offsets 0x59..0x5F, with offset 0x59+i at bits [8i+7:8i]. A stored write is visible there directly after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high chip reset |
| bus_rst | input | 1 | Synchronous bus reset; clears the first shadow byte |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| req_func | input | FUNC_W (3) | Function number |
| req_off | input | 8 | Register offset |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| shadow_attr | output | 8*SHADOW_CNT (56) | Shadow-attribute bytes, lowest offset in the low byte |

## Verification
The bench builds the block with its default parameters. With a 3-bit function field, function numbers 1 through 7 can be reached, next to function 0, for both dropped writes and 0xFF reads. With seven shadow bytes at 0x59, the whole export vector can be compared after chip reset, after individual writes and after bus reset. All 256 offsets are read back after reset, so every default and every untouched zero byte is covered. The other tests target the filter edges 0x0C/0x0D, 0x0E/0x0F and 0x4E/0x4F, the same-cycle read-before-write ordering, and a write that collides with bus reset.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

    localparam int CFG_OFF_W  = 8;
    localparam int CFG_DATA_W = 8;
    localparam int CFG_DEPTH  = 1 << CFG_OFF_W;

    typedef logic [CFG_OFF_W-1:0]  cfg_off_t;
    typedef logic [CFG_DATA_W-1:0] cfg_byte_t;

    // Filtered write as seen by the storage array
    typedef struct packed {
        logic      en;
        cfg_off_t  off;
        cfg_byte_t val;
    } cfg_wr_t;

    typedef enum logic [1:0] {
        RULE_PLAIN,
        RULE_LOCKED,
        RULE_ZERO,
        RULE_MASKED
    } cfg_rule_e;

    function automatic cfg_byte_t cfg_default(input cfg_off_t off);
        case (off)
            8'h00: return 8'h86;
            8'h01: return 8'h80;
            8'h02: return 8'h37;
            8'h03: return 8'h12;
            8'h04: return 8'h03;
            8'h05: return 8'h01;
            8'h06: return 8'h80;
            8'h08: return 8'h02;
            8'h0B: return 8'h06;
            8'h2C: return 8'hF4;
            8'h2D: return 8'h1A;
            8'h2F: return 8'h11;
            8'h51: return 8'h01;
            8'h53: return 8'h80;
            8'h57: return 8'h01;
            8'h58: return 8'h10;
            8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E: return 8'h11;
            8'h5F: return 8'h31;
            8'h72: return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    function automatic cfg_rule_e cfg_rule(input cfg_off_t off);
        if (off >= 8'h10 && off <= 8'h4E) return RULE_LOCKED;
        case (off)
            8'h00, 8'h01, 8'h02, 8'h03,
            8'h08, 8'h09, 8'h0A, 8'h0B, 8'h0C, 8'h0E: return RULE_LOCKED;
            8'h05, 8'h06:                               return RULE_ZERO;
            8'h04, 8'h07:                               return RULE_MASKED;
            default:                                    return RULE_PLAIN;
        endcase
    endfunction

    // Keep mask and forced-one pattern for masked offsets
    function automatic cfg_byte_t cfg_keep(input cfg_off_t off);
        return (off == 8'h04) ? 8'h02 : 8'h80;
    endfunction

    function automatic cfg_byte_t cfg_force(input cfg_off_t off);
        return (off == 8'h04) ? 8'h04 : 8'h02;
    endfunction

endpackage

// File: rtl/hcfg_wr_filter.sv
module hcfg_wr_filter
    import pcicfg_pkg::*;
#(
    parameter int FUNC_W = 3
) (
    input  logic              wr_req,
    input  logic [FUNC_W-1:0] func,
    input  cfg_off_t          off,
    input  cfg_byte_t         wdata,
    output cfg_wr_t           wr_out
);

    cfg_rule_e rule;

    always_comb begin
        rule          = cfg_rule(off);
        wr_out.off    = off;
        wr_out.en     = wr_req && (func == '0) && (rule != RULE_LOCKED);
        unique case (rule)
            RULE_ZERO:   wr_out.val = '0;
            RULE_MASKED: wr_out.val = (wdata & cfg_keep(off)) | cfg_force(off);
            default:     wr_out.val = wdata;
        endcase
    end

endmodule

// File: rtl/hcfg_byte_array.sv
module hcfg_byte_array
    import pcicfg_pkg::*;
#(
    parameter int CLR_OFF = 8'h59
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           clr,
    input  cfg_wr_t                        wr,
    output logic [CFG_DEPTH-1:0][CFG_DATA_W-1:0] bytes
);

    for (genvar i = 0; i < CFG_DEPTH; i++) begin : g_byte
        localparam cfg_byte_t DFLT = cfg_default(cfg_off_t'(i));
        localparam bit        CLEARABLE = (i == CLR_OFF);

        always_ff @(posedge clk) begin
            if (rst) begin
                bytes[i] <= DFLT;
            end else if (CLEARABLE && clr) begin
                bytes[i] <= '0;
            end else if (wr.en && (wr.off == cfg_off_t'(i))) begin
                bytes[i] <= wr.val;
            end
        end
    end

endmodule

// File: rtl/hcfg_read_port.sv
module hcfg_read_port
    import pcicfg_pkg::*;
#(
    parameter int FUNC_W = 3
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 rd_req,
    input  logic [FUNC_W-1:0]                    func,
    input  cfg_off_t                             off,
    input  logic [CFG_DEPTH-1:0][CFG_DATA_W-1:0] bytes,
    output cfg_byte_t                            rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_req) begin
            rd_data <= (func != '0) ? '1 : bytes[off];
        end
    end

endmodule

// File: rtl/host_cfg_space.sv
module host_cfg_space
    import pcicfg_pkg::*;
#(
    parameter int FUNC_W      = 3,
    parameter int SHADOW_BASE = 8'h59,
    parameter int SHADOW_CNT  = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bus_rst,
    input  logic                       req_rd,
    input  logic                       req_wr,
    input  logic [FUNC_W-1:0]          req_func,
    input  logic [7:0]                 req_off,
    input  logic [7:0]                 req_wdata,
    output logic [7:0]                 rd_data,
    output logic [8*SHADOW_CNT-1:0]    shadow_attr
);

    localparam int SHADOW_W = CFG_DATA_W * SHADOW_CNT;

    cfg_wr_t                              wr_f;
    logic [CFG_DEPTH-1:0][CFG_DATA_W-1:0] bytes;

    hcfg_wr_filter #(.FUNC_W(FUNC_W)) u_filter (
        .wr_req (req_wr),
        .func   (req_func),
        .off    (req_off),
        .wdata  (req_wdata),
        .wr_out (wr_f)
    );

    hcfg_byte_array #(.CLR_OFF(SHADOW_BASE)) u_array (
        .clk   (clk),
        .rst   (rst),
        .clr   (bus_rst),
        .wr    (wr_f),
        .bytes (bytes)
    );

    hcfg_read_port #(.FUNC_W(FUNC_W)) u_read (
        .clk     (clk),
        .rst     (rst),
        .rd_req  (req_rd),
        .func    (req_func),
        .off     (req_off),
        .bytes   (bytes),
        .rd_data (rd_data)
    );

    for (genvar s = 0; s < SHADOW_CNT; s++) begin : g_shadow
        assign shadow_attr[CFG_DATA_W*s +: CFG_DATA_W] = bytes[SHADOW_BASE + s];
    end

    if (SHADOW_W != 8 * SHADOW_CNT) begin : g_bad_width
        initial $error("shadow width mismatch");
    end

endmodule

// File: rtl/hcfg_checker.sv
module hcfg_checker
    import pcicfg_pkg::*;
#(
    parameter int FUNC_W      = 3,
    parameter int SHADOW_BASE = 8'h59,
    parameter int SHADOW_CNT  = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    bus_rst,
    input logic                    req_rd,
    input logic                    req_wr,
    input logic [FUNC_W-1:0]       req_func,
    input logic [7:0]              req_off,
    input logic [7:0]              req_wdata,
    input logic [7:0]              rd_data,
    input logic [8*SHADOW_CNT-1:0] shadow_attr
);

    function automatic logic [8*SHADOW_CNT-1:0] shadow_reset();
        logic [8*SHADOW_CNT-1:0] v;
        for (int k = 0; k < SHADOW_CNT; k++) begin
            v[8*k +: 8] = cfg_default(cfg_off_t'(SHADOW_BASE + k));
        end
        return v;
    endfunction

    localparam logic [8*SHADOW_CNT-1:0] SHADOW_RST = shadow_reset();
    localparam logic [7:0] SECOND_OFF = 8'(SHADOW_BASE + 1);

    // R1
    r1_shadow_default_chk: assert property (@(posedge clk)
        rst |=> shadow_attr == SHADOW_RST);

    // R2
    r2_foreign_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr && req_func != '0 && !bus_rst) |=> $stable(shadow_attr));

    // R2
    r2_foreign_read_chk: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_func != '0) |=> rd_data == 8'hFF);

    // R7
    r7_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_rd |=> $stable(rd_data));

    // R8
    r8_bus_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> shadow_attr[7:0] == 8'h00);

    // R8
    r8_bus_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rst && !req_wr) |=> $stable(shadow_attr[8*SHADOW_CNT-1:8]));

    // R9
    r9_export_write_chk: assert property (@(posedge clk) disable iff (rst)
        (req_wr && req_func == '0 && req_off == SECOND_OFF)
        |=> shadow_attr[15:8] == $past(req_wdata));

endmodule

bind host_cfg_space hcfg_checker #(
    .FUNC_W      (FUNC_W),
    .SHADOW_BASE (SHADOW_BASE),
    .SHADOW_CNT  (SHADOW_CNT)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rst     (bus_rst),
    .req_rd      (req_rd),
    .req_wr      (req_wr),
    .req_func    (req_func),
    .req_off     (req_off),
    .req_wdata   (req_wdata),
    .rd_data     (rd_data),
    .shadow_attr (shadow_attr)
);

// File: tb/host_cfg_space_test.sv
`timescale 1ns/1ps
module host_cfg_space_test;

    localparam int FUNC_W = 3;
    localparam int SCNT   = 7;

    logic              clk = 0;
    logic              rst = 1;
    logic              bus_rst = 0;
    logic              req_rd = 0;
    logic              req_wr = 0;
    logic [FUNC_W-1:0] req_func = '0;
    logic [7:0]        req_off = '0;
    logic [7:0]        req_wdata = '0;
    logic [7:0]        rd_data;
    logic [8*SCNT-1:0] shadow_attr;

    int checks = 0;
    int errors = 0;

    logic [7:0] model [256];
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_pend = 0;
    logic [7:0] last_exp = 8'h00;

    always #4 clk = ~clk;

    host_cfg_space uut (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .req_rd(req_rd), .req_wr(req_wr),
        .req_func(req_func), .req_off(req_off), .req_wdata(req_wdata),
        .rd_data(rd_data), .shadow_attr(shadow_attr)
    );

    function automatic logic [7:0] dflt(input int o);
        case (o)
            8'h00: return 8'h86;  8'h01: return 8'h80;
            8'h02: return 8'h37;  8'h03: return 8'h12;
            8'h04: return 8'h03;  8'h05: return 8'h01;
            8'h06: return 8'h80;  8'h08: return 8'h02;
            8'h0B: return 8'h06;  8'h2C: return 8'hF4;
            8'h2D: return 8'h1A;  8'h2F: return 8'h11;
            8'h51: return 8'h01;  8'h53: return 8'h80;
            8'h57: return 8'h01;  8'h58: return 8'h10;
            8'h5A, 8'h5B, 8'h5C, 8'h5D, 8'h5E: return 8'h11;
            8'h5F: return 8'h31;  8'h72: return 8'h02;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Update the bench model for a write, from R2..R6 and R8
    task automatic model_write(input int f, input int o, input logic [7:0] d);
        if (f != 0) return;
        if ((o >= 8'h10 && o <= 8'h4E) || o <= 3 || (o >= 8'h08 && o <= 8'h0C) || o == 8'h0E)
            return;
        if (o == 8'h04)                  model[o] = (d & 8'h02) | 8'h04;
        else if (o == 8'h05 || o == 8'h06) model[o] = 8'h00;
        else if (o == 8'h07)             model[o] = (d & 8'h80) | 8'h02;
        else                             model[o] = d;
    endtask

    // Driver: one request per cycle, set at the falling edge
    task automatic access(input bit rd, input bit wr, input int f, input int o,
                          input logic [7:0] d, input bit brst, input string tag);
        @(negedge clk);
        req_rd    = rd;
        req_wr    = wr;
        req_func  = FUNC_W'(f);
        req_off   = 8'(o);
        req_wdata = d;
        bus_rst   = brst;
        if (rd) begin
            exp_q.push_back((f != 0) ? 8'hFF : model[o]);
            tag_q.push_back(tag);
        end
        if (wr) model_write(f, o, d);
        if (brst) model[8'h59] = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) access(0, 0, 0, 0, 8'h00, 0, "");
    endtask

    task automatic wr(input int f, input int o, input logic [7:0] d);
        access(0, 1, f, o, d, 0, "");
    endtask

    task automatic rd(input int f, input int o, input string tag);
        access(1, 0, f, o, 8'h00, 0, tag);
    endtask

    function automatic logic [8*SCNT-1:0] model_shadow();
        logic [8*SCNT-1:0] v;
        for (int k = 0; k < SCNT; k++) v[8*k +: 8] = model[8'h59 + k];
        return v;
    endfunction

    // Monitor: compare each registered read against the scoreboard
    always @(posedge clk) rd_pend <= req_rd && !rst;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected read", 0, 1);
            end else begin
                last_exp = exp_q.pop_front();
                check(tag_q.pop_front(), {56'h0, rd_data}, {56'h0, last_exp});
            end
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = dflt(i);
        repeat (3) @(negedge clk);
        check("R1 rd_data during reset", {56'h0, rd_data}, 64'h0);
        @(negedge clk);
        rst = 0;

        // R1: shadow export and every offset after reset
        check("R1/R9 shadow after reset", {8'h0, shadow_attr}, {8'h0, model_shadow()});
        for (int o = 0; o < 256; o++) rd(0, o, "R1 reset default");

        // R2: foreign function writes and reads
        wr(3, 8'h50, 8'hAA);
        wr(7, 8'h5C, 8'h3C);
        rd(0, 8'h50, "R2 foreign write dropped");
        rd(0, 8'h5C, "R2 foreign write dropped shadow");
        rd(5, 8'h00, "R2 foreign read");
        rd(1, 8'h72, "R2 foreign read");

        // R3: locked offsets
        wr(0, 8'h00, 8'h5A); wr(0, 8'h03, 8'h5A); wr(0, 8'h0A, 8'h5A);
        wr(0, 8'h0C, 8'h5A); wr(0, 8'h0E, 8'h5A); wr(0, 8'h10, 8'h5A);
        wr(0, 8'h2C, 8'h5A); wr(0, 8'h4E, 8'h5A);
        rd(0, 8'h00, "R3 id locked"); rd(0, 8'h03, "R3 id locked");
        rd(0, 8'h0A, "R3 class locked"); rd(0, 8'h0C, "R3 locked");
        rd(0, 8'h0E, "R3 locked"); rd(0, 8'h10, "R3 range start");
        rd(0, 8'h2C, "R3 range mid"); rd(0, 8'h4E, "R3 range end");

        // R4 / R5: masked and forced bits
        wr(0, 8'h04, 8'hFF); rd(0, 8'h04, "R4 command all ones");
        wr(0, 8'h04, 8'h00); rd(0, 8'h04, "R4 command zero");
        wr(0, 8'h05, 8'hFF); rd(0, 8'h05, "R4 offset 05 zero");
        wr(0, 8'h06, 8'hFF); rd(0, 8'h06, "R4 offset 06 zero");
        wr(0, 8'h07, 8'hFF); rd(0, 8'h07, "R5 status all ones");
        wr(0, 8'h07, 8'h7D); rd(0, 8'h07, "R5 status low bits");

        // R6: plain offsets
        wr(0, 8'h0D, 8'h21); wr(0, 8'h0F, 8'h42); wr(0, 8'h4F, 8'h63);
        wr(0, 8'h50, 8'h84); wr(0, 8'h72, 8'hA5); wr(0, 8'hFF, 8'hC6);
        rd(0, 8'h0D, "R6 plain 0D"); rd(0, 8'h0F, "R6 plain 0F");
        rd(0, 8'h4F, "R6 plain 4F"); rd(0, 8'h50, "R6 plain 50");
        rd(0, 8'h72, "R6 plain 72"); rd(0, 8'hFF, "R6 plain FF");

        // R9: shadow export follows writes
        wr(0, 8'h59, 8'hF0); wr(0, 8'h5A, 8'h33); wr(0, 8'h5F, 8'h0C);
        idle(1);
        check("R9 shadow after writes", {8'h0, shadow_attr}, {8'h0, model_shadow()});
        check("R9 shadow byte order", {56'h0, shadow_attr[55:48]}, 64'h0C);

        // R7: read and write in one cycle returns old value, then hold
        access(1, 0, 0, 8'h60, 8'h00, 0, "R7 pre read");
        begin
            logic [7:0] old_v = model[8'h60];
            @(negedge clk);
            req_rd = 1; req_wr = 1; req_func = '0; req_off = 8'h60; req_wdata = 8'h9E;
            bus_rst = 0;
            exp_q.push_back(old_v); tag_q.push_back("R7 same-cycle old value");
            model_write(0, 8'h60, 8'h9E);
        end
        rd(0, 8'h60, "R7 new value after write");
        idle(4);
        check("R7 hold without strobe", {56'h0, rd_data}, {56'h0, model[8'h60]});

        // R8: bus reset clears only the first shadow byte
        access(0, 0, 0, 0, 8'h00, 1, "");
        idle(1);
        check("R8 bus reset shadow", {8'h0, shadow_attr}, {8'h0, model_shadow()});
        rd(0, 8'h59, "R8 cleared"); rd(0, 8'h5A, "R8 neighbour kept");
        rd(0, 8'h50, "R8 other kept"); rd(0, 8'h04, "R8 command kept");
        access(0, 1, 0, 8'h59, 8'h77, 1, "");
        rd(0, 8'h59, "R8 bus reset beats write");
        access(0, 1, 0, 8'h5B, 8'h55, 1, "");
        rd(0, 8'h5B, "R8 other write with bus reset");
        rd(0, 8'h59, "R8 cleared again");

        // R1: chip reset restores defaults
        @(negedge clk);
        req_rd = 0; req_wr = 0; bus_rst = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 256; i++) model[i] = dflt(i);
        check("R1 shadow after second reset", {8'h0, shadow_attr}, {8'h0, model_shadow()});
        rd(0, 8'h04, "R1 reload command"); rd(0, 8'h60, "R1 reload cleared");
        rd(0, 8'h5F, "R1 reload shadow top");
        idle(3);

        check("R7 scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule